// File: doc/BRIEF.md
# ALU Status Flag Register

This block is the flag-generation logic and status register of a small 8-bit accumulator-style processor core. It runs one arithmetic, logic, clear, rotate or move operation on two 8-bit operands. It returns the result without a clock, and it captures the zero, nibble-carry and carry flags of that operation in the 8-bit status register. It also tracks two power-state bits: a time-out flag and a power-down flag. These change only on single-cycle device events (power-up, watchdog clear, sleep entry and watchdog timeout), never on a data write.

An instruction is carried out by pulsing `exec_i` with an operation code, operands and a destination register address. When the destination is the status register's own address, the result is written into the register under masking rules:
- The page bits take the result.
- The power bits never take it.
- Any operation that updates a flag keeps all three flags away from the written data.

The two-bit page field drives program-address bits 10:9, so it selects one of four 512-word pages.

Top module: `alu_status_reg`

## Requirements
- R1: After a cycle with `rst_n` low, `status_o` is 8'h18. The page bits 7:5 are 0, time-out (bit 4) and power-down (bit 3) are 1, and Z (bit 2), DC (bit 1) and C (bit 0) are 0. `page_addr_o` is 0.
- R2: Op code 1 (add) gives `result_o` = (a+b) mod 256. On the next edge with `exec_i` high, Z is set when the result is zero, DC takes the carry out of bit 3 and C takes the carry out of bit 7.
- R3: Op code 2 (subtract) gives `result_o` = (a-b) mod 256. DC is 1 exactly when a[3:0] >= b[3:0] (no nibble borrow). C is 1 exactly when a >= b (no borrow). Z marks a zero result.
- R4: Op codes 3, 4 and 5 (AND, OR, XOR) give the bitwise result and update only Z. DC and C keep their values.
- R5: Op code 7 (rotate right) gives {C, a[7:1]} and loads C with a[0]. Op code 8 (rotate left) gives {a[6:0], C} and loads C with a[7]. Z and DC keep their values.
- R6: Op code 0 (move, `result_o` = b) affects no flag. Codes 9 to 15 act as code 0. A move to the status address writes result bits 7:5 and 2:0 into the register and leaves bits 4:3 unchanged.
- R7: When a flag-updating operation targets the status address, bits 7:5 take the result. The flags that the operation updates take their computed values. The other flags and bits 4:3 keep their values. Op code 6 (clear, result 0) therefore leaves the pattern 000uu1uu, where u means unchanged.
- R8: The time-out bit is set by power-up. Otherwise it is cleared by a watchdog timeout, even if a watchdog clear or sleep arrives in the same cycle. Otherwise it is set by a watchdog clear or a sleep event. With no event it holds.
- R9: The power-down bit is set by power-up. Otherwise it is cleared by sleep, even with a watchdog clear in the same cycle. Otherwise it is set by a watchdog clear. With no event it holds.
- R10: `page_addr_o` equals status bits 6:5.
- R11: With `exec_i` low, the page bits and flags hold. An operation aimed at another address leaves the page bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Carry out the operation this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (rotate source) |
| b_i | input | 8 | Second operand (move source) |
| dst_addr_i | input | 5 | Destination register address |
| evt_por_i | input | 1 | Power-up event pulse |
| evt_wdt_clr_i | input | 1 | Watchdog-clear event pulse |
| evt_sleep_i | input | 1 | Sleep-entry event pulse |
| evt_wdt_to_i | input | 1 | Watchdog-timeout event pulse |
| result_o | output | 8 | Combinational operation result |
| status_o | output | 8 | Status register contents |
| page_addr_o | output | 2 | Program-address bits 10:9 |

## Verification
The bench presets the flags before each operation, so carry-in and held flags are known values. It then probes these corner cases:
- Nibble-carry boundaries in both directions, equal-operand subtraction and carries out of bit 7. Swapped borrow polarity or a wrong nibble tap shows up as wrong DC and C values.
- Writes to the status address by a move, an add and a clear, with data bits chosen to differ from the computed flags. A design that lets data through on flag bits or power bits reports those data bits instead of 000uu1uu-style patterns.
- Simultaneous events (timeout with clear, sleep with clear, power-up with timeout and with sleep). These expose a wrong priority.
- Idle cycles and writes to other addresses. These catch a register that loads without `exec_i`.

// File: rtl/status_pkg.sv
// Shared constants and the operation encoding for the ALU status block.
// Assumes an 8-bit datapath with a 4-bit nibble for the digit carry.
package status_pkg;
    localparam int DW       = 8;
    localparam int NIB      = 4;
    localparam int ADDR_W   = 5;
    localparam int PAGE_W   = 2;
    localparam int UPPER_W  = 3;
    localparam int FLAG_W   = 3;
    localparam int BIT_C    = 0;
    localparam int BIT_DC   = 1;
    localparam int BIT_Z    = 2;
    localparam int BIT_PD   = 3;
    localparam int BIT_TO   = 4;
    localparam int PAGE_LSB = 5;
    localparam int OP_W     = 4;

    typedef enum logic [OP_W-1:0] {
        OP_MOV = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_CLR = 4'd6,
        OP_RRC = 4'd7,
        OP_RLC = 4'd8
    } alu_op_e;
endpackage

// File: rtl/alu_flag_unit.sv
// Combinational ALU with flag generation and per-flag update enables.
// Subtraction is a + ~b + 1, so the carry-outs are the not-borrow values.
// Assumes c_in is the current carry flag (used by rotates only).
module alu_flag_unit
    import status_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           c_in,
    output logic [DW-1:0]  res,
    output logic           z_new,
    output logic           dc_new,
    output logic           c_new,
    output logic           upd_z,
    output logic           upd_dc,
    output logic           upd_c
);
    logic          is_sub;
    logic [DW-1:0] b_eff;
    logic [DW:0]   sum_full;
    logic [NIB:0]  sum_lo;

    // Purpose: shared adder for add and subtract, with the nibble carry tap.
    always_comb begin
        is_sub   = (op == OP_SUB);
        b_eff    = is_sub ? ~b : b;
        sum_full = {1'b0, a} + {1'b0, b_eff} + (DW+1)'(is_sub);
        sum_lo   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + (NIB+1)'(is_sub);
    end

    // Purpose: select the result and the flags each operation updates.
    always_comb begin
        res    = b;
        c_new  = c_in;
        dc_new = sum_lo[NIB];
        upd_z  = 1'b0;
        upd_dc = 1'b0;
        upd_c  = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                res    = sum_full[DW-1:0];
                c_new  = sum_full[DW];
                upd_z  = 1'b1;
                upd_dc = 1'b1;
                upd_c  = 1'b1;
            end
            OP_AND: begin res = a & b; upd_z = 1'b1; end
            OP_OR:  begin res = a | b; upd_z = 1'b1; end
            OP_XOR: begin res = a ^ b; upd_z = 1'b1; end
            OP_CLR: begin res = '0;    upd_z = 1'b1; end
            OP_RRC: begin
                res   = {c_in, a[DW-1:1]};
                c_new = a[0];
                upd_c = 1'b1;
            end
            OP_RLC: begin
                res   = {a[DW-2:0], c_in};
                c_new = a[DW-1];
                upd_c = 1'b1;
            end
            default: res = b;
        endcase
        z_new = (res == '0);
    end
endmodule

// File: rtl/power_flags.sv
// Time-out and power-down bits, driven only by device event pulses.
// Priority: power-up over everything; timeout over clear/sleep for the
// time-out bit; sleep over clear for the power-down bit.
module power_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_por,
    input  logic evt_wdt_clr,
    input  logic evt_sleep,
    input  logic evt_wdt_to,
    output logic to_q,
    output logic pd_q
);
    // Purpose: prioritised update of the time-out bit.
    always_ff @(posedge clk) begin
        if (!rst_n || evt_por)        to_q <= 1'b1;
        else if (evt_wdt_to)          to_q <= 1'b0;
        else if (evt_wdt_clr || evt_sleep) to_q <= 1'b1;
    end

    // Purpose: prioritised update of the power-down bit.
    always_ff @(posedge clk) begin
        if (!rst_n || evt_por)  pd_q <= 1'b1;
        else if (evt_sleep)     pd_q <= 1'b0;
        else if (evt_wdt_clr)   pd_q <= 1'b1;
    end

    AST_POR_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        evt_por |=> (to_q && pd_q)); // R8
    AST_TIMEOUT_CLEARS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_por && evt_wdt_to) |=> !to_q); // R8
    AST_SLEEP_CLEARS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_por && evt_sleep) |=> !pd_q); // R9
    AST_POWER_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_por || evt_wdt_clr || evt_sleep || evt_wdt_to)
        |=> ($stable(to_q) && $stable(pd_q))); // R9
endmodule

// File: rtl/status_reg.sv
// Page bits and arithmetic flags of the status register with write masking.
// A write to the status address loads the page bits always, and the flags
// only when the operation updates none of them.
module status_reg
    import status_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec,
    input  logic               dst_hit,
    input  logic [UPPER_W-1:0] wr_upper,
    input  logic [FLAG_W-1:0]  wr_flags,
    input  logic               z_new,
    input  logic               dc_new,
    input  logic               c_new,
    input  logic               upd_z,
    input  logic               upd_dc,
    input  logic               upd_c,
    output logic [UPPER_W-1:0] upper_q,
    output logic [FLAG_W-1:0]  flags_q
);
    logic                any_upd;
    logic                data_wr;
    logic [FLAG_W-1:0]   upd_vec;
    logic [FLAG_W-1:0]   calc_vec;

    // Purpose: decide whether written data may reach the flag bits.
    always_comb begin
        any_upd  = upd_z || upd_dc || upd_c;
        data_wr  = exec && dst_hit && !any_upd;
        upd_vec  = '0;
        calc_vec = '0;
        upd_vec[BIT_Z]   = upd_z;
        upd_vec[BIT_DC]  = upd_dc;
        upd_vec[BIT_C]   = upd_c;
        calc_vec[BIT_Z]  = z_new;
        calc_vec[BIT_DC] = dc_new;
        calc_vec[BIT_C]  = c_new;
    end

    // Purpose: page and spare bits load from data on a status-address write.
    always_ff @(posedge clk) begin
        if (!rst_n)              upper_q <= '0;
        else if (exec && dst_hit) upper_q <= wr_upper;
    end

    // Purpose: each flag loads its computed value, written data, or holds.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                    flags_q[i] <= 1'b0;
            else if (exec && upd_vec[i])   flags_q[i] <= calc_vec[i];
            else if (data_wr)              flags_q[i] <= wr_flags[i];
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> ($stable(upper_q) && $stable(flags_q))); // R11
    AST_OTHER_DST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !dst_hit) |=> $stable(upper_q)); // R11
    AST_FLAG_OP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dst_hit && any_upd && !upd_c) |=> $stable(flags_q[BIT_C])); // R7
endmodule

// File: rtl/alu_status_reg.sv
// Top: ALU flag generation plus the 8-bit status register and page output.
// The operation result is the data written to the destination register.
module alu_status_reg
    import status_pkg::*;
#(
    parameter int STATUS_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic              evt_por_i,
    input  logic              evt_wdt_clr_i,
    input  logic              evt_sleep_i,
    input  logic              evt_wdt_to_i,
    output logic [DW-1:0]     result_o,
    output logic [DW-1:0]     status_o,
    output logic [PAGE_W-1:0] page_addr_o
);
    alu_op_e            op;
    logic               dst_hit;
    logic               z_new, dc_new, c_new;
    logic               upd_z, upd_dc, upd_c;
    logic               to_q, pd_q;
    logic [UPPER_W-1:0] upper_q;
    logic [FLAG_W-1:0]  flags_q;

    // Purpose: decode the op code and the destination match.
    always_comb begin
        op      = alu_op_e'(op_i);
        dst_hit = (dst_addr_i == ADDR_W'(STATUS_ADDR));
    end

    alu_flag_unit u_alu (
        .op     (op),
        .a      (a_i),
        .b      (b_i),
        .c_in   (flags_q[BIT_C]),
        .res    (result_o),
        .z_new  (z_new),
        .dc_new (dc_new),
        .c_new  (c_new),
        .upd_z  (upd_z),
        .upd_dc (upd_dc),
        .upd_c  (upd_c)
    );

    status_reg u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec     (exec_i),
        .dst_hit  (dst_hit),
        .wr_upper (result_o[DW-1:PAGE_LSB]),
        .wr_flags (result_o[FLAG_W-1:0]),
        .z_new    (z_new),
        .dc_new   (dc_new),
        .c_new    (c_new),
        .upd_z    (upd_z),
        .upd_dc   (upd_dc),
        .upd_c    (upd_c),
        .upper_q  (upper_q),
        .flags_q  (flags_q)
    );

    power_flags u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_por     (evt_por_i),
        .evt_wdt_clr (evt_wdt_clr_i),
        .evt_sleep   (evt_sleep_i),
        .evt_wdt_to  (evt_wdt_to_i),
        .to_q        (to_q),
        .pd_q        (pd_q)
    );

    // Purpose: assemble the register image and the page address bits.
    always_comb begin
        status_o    = {upper_q, to_q, pd_q, flags_q};
        page_addr_o = status_o[PAGE_LSB +: PAGE_W];
    end

    AST_RESET_IMAGE: assert property (@(posedge clk)
        !rst_n |=> (status_o == 8'h18)); // R1
    AST_SUB_CARRY_IS_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op == OP_SUB) |-> (c_new == (a_i >= b_i))); // R3
    AST_CLR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && dst_hit && op == OP_CLR && !evt_por_i && !evt_wdt_clr_i
         && !evt_sleep_i && !evt_wdt_to_i)
        |=> (status_o[7:5] == 3'b000 && status_o[BIT_Z]
             && $stable(status_o[4:3]) && $stable(status_o[1:0]))); // R7
    AST_MOV_NO_POWER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && dst_hit && !evt_por_i && !evt_wdt_clr_i && !evt_sleep_i
         && !evt_wdt_to_i) |=> $stable(status_o[4:3])); // R6
endmodule

// File: tb/alu_status_reg_tb.sv
module alu_status_reg_tb;
    localparam logic [4:0] ST  = 5'd3;
    localparam logic [4:0] OTH = 5'd16;
    localparam int NV = 17;
    // {op[33:30], a[29:22], b[21:14], preset ZDCC[13:11], result[10:3], flags ZDCC[2:0]}
    localparam logic [33:0] VEC [NV] = '{
        {4'd1, 8'h0F, 8'h01, 3'b000, 8'h10, 3'b010},  // R2 nibble carry
        {4'd1, 8'hFF, 8'h01, 3'b000, 8'h00, 3'b111},  // R2 full wrap
        {4'd1, 8'h80, 8'h80, 3'b000, 8'h00, 3'b101},  // R2 bit7 carry only
        {4'd1, 8'h12, 8'h34, 3'b111, 8'h46, 3'b000},  // R2 no carry
        {4'd2, 8'h05, 8'h03, 3'b000, 8'h02, 3'b011},  // R3 no borrow
        {4'd2, 8'h03, 8'h05, 3'b111, 8'hFE, 3'b000},  // R3 borrow
        {4'd2, 8'h10, 8'h01, 3'b000, 8'h0F, 3'b001},  // R3 nibble borrow
        {4'd2, 8'h42, 8'h42, 3'b000, 8'h00, 3'b111},  // R3 equal
        {4'd3, 8'hF0, 8'h0F, 3'b011, 8'h00, 3'b111},  // R4 and
        {4'd4, 8'h50, 8'h0A, 3'b110, 8'h5A, 3'b010},  // R4 or
        {4'd5, 8'hAA, 8'hAA, 3'b001, 8'h00, 3'b101},  // R4 xor
        {4'd7, 8'h81, 8'h00, 3'b000, 8'h40, 3'b001},  // R5 rrc
        {4'd7, 8'h02, 8'h00, 3'b111, 8'h81, 3'b110},  // R5 rrc c in
        {4'd8, 8'h81, 8'h00, 3'b000, 8'h02, 3'b001},  // R5 rlc
        {4'd8, 8'h00, 8'h00, 3'b001, 8'h01, 3'b000},  // R5 rlc c in
        {4'd6, 8'h33, 8'h44, 3'b011, 8'h00, 3'b111},  // R7 clr flags
        {4'd0, 8'h99, 8'h00, 3'b111, 8'h00, 3'b111}   // R6 mov no flags
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exec_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0;
    logic [4:0] dst_addr_i = '0;
    logic evt_por_i = 1'b0, evt_wdt_clr_i = 1'b0, evt_sleep_i = 1'b0, evt_wdt_to_i = 1'b0;
    logic [7:0] result_o, status_o;
    logic [1:0] page_addr_o;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    alu_status_reg u_dut (.*);

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic [4:0] dst, output logic [7:0] res);
        op_i = op; a_i = a; b_i = b; dst_addr_i = dst; exec_i = 1'b1;
        #1 res = result_o;
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    task automatic pulse(input logic por, input logic clr, input logic slp, input logic tmo);
        evt_por_i = por; evt_wdt_clr_i = clr; evt_sleep_i = slp; evt_wdt_to_i = tmo;
        @(negedge clk);
        evt_por_i = 0; evt_wdt_clr_i = 0; evt_sleep_i = 0; evt_wdt_to_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        check("R1 reset status", status_o, 8'h18);
        check("R1 reset page", {6'd0, page_addr_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(4'd0, 8'h00, {5'd0, VEC[i][13:11]}, ST, r);
            run_op(VEC[i][33:30], VEC[i][29:22], VEC[i][21:14], OTH, r);
            check($sformatf("R2-R7 vec%0d result", i), r, VEC[i][10:3]);
            check($sformatf("R2-R7 vec%0d flags", i), {5'd0, status_o[2:0]}, {5'd0, VEC[i][2:0]});
        end

        // R9 / R6: sleep, then a move to status must not touch TO/PD
        pulse(0, 0, 1, 0);
        run_op(4'd0, 8'h00, 8'h00, ST, r);
        check("R6 mov keeps TO PD", status_o, 8'h10);
        run_op(4'd0, 8'h00, 8'h40, ST, r);
        check("R10 page field", status_o, 8'h50);
        check("R10 page addr", {6'd0, page_addr_o}, 8'h02);
        run_op(4'd12, 8'h00, 8'hFF, ST, r);
        check("R6 unlisted code acts as move", status_o, 8'hF7);
        // R7: add to status, data flag bits (101) ignored
        run_op(4'd1, 8'hE0, 8'h05, ST, r);
        check("R7 add to status", status_o, 8'hF0);
        run_op(4'd1, 8'hFF, 8'h02, ST, r);
        check("R7 add to status flags", status_o, 8'h13);
        run_op(4'd6, 8'h00, 8'h00, ST, r);
        check("R7 clr pattern", status_o, 8'h17);
        // R11
        run_op(4'd0, 8'h00, 8'h60, ST, r);
        check("R11 setup", status_o, 8'h70);
        run_op(4'd0, 8'h00, 8'hFF, OTH, r);
        check("R11 other dest", status_o, 8'h70);
        op_i = 4'd1; a_i = 8'hFF; b_i = 8'h01; dst_addr_i = ST; exec_i = 1'b0;
        @(negedge clk);
        check("R11 exec low", status_o, 8'h70);

        // R8 / R9 events: status bits 4:3 = {TO,PD}
        pulse(0, 0, 0, 1);
        check("R8 timeout", {6'd0, status_o[4:3]}, 8'h00);
        pulse(0, 0, 0, 0);
        check("R9 hold", {6'd0, status_o[4:3]}, 8'h00);
        pulse(0, 1, 0, 0);
        check("R8 R9 wdt clear", {6'd0, status_o[4:3]}, 8'h03);
        pulse(0, 0, 1, 0);
        check("R9 sleep", {6'd0, status_o[4:3]}, 8'h02);
        pulse(0, 1, 0, 1);
        check("R8 timeout beats clear", {6'd0, status_o[4:3]}, 8'h01);
        pulse(0, 1, 1, 0);
        check("R9 sleep beats clear", {6'd0, status_o[4:3]}, 8'h02);
        pulse(1, 0, 1, 1);
        check("R8 R9 power-up wins", {6'd0, status_o[4:3]}, 8'h03);
        check("R8 events leave page", {5'd0, status_o[7:5]}, 8'h03);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule